// File: doc/BRIEF.md
# System Management Interrupt Aggregator

This block gathers interrupt events from eight on-chip peripheral sources, plus one keyboard-controller port pin, into a single active-low system management interrupt. Each source owns a sticky status bit. The status bit latches whenever the source fires, even when that source is not enabled. The group interrupt is asserted when at least one source has both its status bit and its enable bit set.

Four byte-wide registers sit behind a simple register port at indices 0xB4 to 0xB7: two enable registers and two status registers. A dedicated enable bit forwards the group interrupt to a request output for a serial-IRQ frame encoder. This path is separate from the direct pin. Both outputs are registered.

Source bit order in the first enable and first status registers is: bit 0 second UART, bit 1 first UART, bit 2 floppy, bit 3 watchdog, bit 4 mouse, bit 5 keyboard, bit 6 infrared, bit 7 parallel port.

Top module: `smi_group_ctrl`

## Requirements
- R1: After reset all enable and status bits read 0, `smi_n_o` is 1 and `smi_frame_o` is 0.
- R2: Index 0xB4 holds a read/write source enable byte. Index 0xB5 holds two writable bits, bit 0 (pin route) and bit 6 (frame enable); its other bits read 0.
- R3: A high `src_evt_i[k]` sets bit k of index 0xB6 at the next clock edge, whatever the enables hold. No status bit rises without its event.
- R4: Writing 1 to a status bit at 0xB6 or 0xB7 clears it. Writing 0 leaves it unchanged.
- R5: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: `smi_n_o` is 0 exactly one cycle after some source has status and enable both set, and 1 otherwise.
- R7: A high `kbc_pin_i` sets bit 0 of 0xB7. That bit asserts the group interrupt only when bit 0 of 0xB5 is 1.
- R8: `smi_frame_o` is 1 exactly when the group interrupt is asserted and bit 6 of 0xB5 is 1, with the same one-cycle timing as `smi_n_o`.
- R9: Writes to indices outside 0xB4 to 0xB7 change nothing. Reads there return 0.
- R10: Clearing an enable bit releases `smi_n_o` one cycle later. The latched status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_evt_i | input | 8 | Peripheral interrupt events, one per source |
| kbc_pin_i | input | 1 | Keyboard-controller port pin event |
| reg_addr_i | input | 8 | Register index |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| smi_n_o | output | 1 | Group system management interrupt, active low |
| smi_frame_o | output | 1 | Group interrupt request toward the serial-IRQ frame encoder |

## Verification
The hardest case to reach from the ports is an event and a clearing write landing on the same status bit in the same clock cycle. The bench reaches it by driving a source pulse and a write-one-to-clear of that bit on the same falling edge. The same write also clears a second, already latched bit, so a single read shows both that the set wins and that the clear still acts elsewhere. The bench also latches a disabled source and then confirms the pin stays high. Only when the matching enable is written does it expect the pin to drop.

// File: rtl/smi_pkg.sv
package smi_pkg;
    // Register slot inside the four-entry window, order fixed by the index map
    typedef enum logic [1:0] {
        SLOT_EN_A = 2'd0,
        SLOT_EN_B = 2'd1,
        SLOT_ST_A = 2'd2,
        SLOT_ST_B = 2'd3
    } smi_slot_e;

    localparam int unsigned NUM_SLOTS = 4;
endpackage

// File: rtl/smi_reg_decode.sv
module smi_reg_decode
    import smi_pkg::*;
#(
    parameter int unsigned            ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]      BASE_ADDR = 'hB4
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_i,
    output logic                 hit_o,
    output smi_slot_e            slot_o,
    output logic [NUM_SLOTS-1:0] wr_sel_o
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset   = addr_i - BASE_ADDR;
        hit_o    = offset < ADDR_W'(NUM_SLOTS);
        slot_o   = smi_slot_e'(offset[1:0]);
        wr_sel_o = '0;
        if (hit_o && wr_i) begin
            wr_sel_o[slot_o] = 1'b1;
        end
    end
endmodule

// File: rtl/smi_status_bank.sv
module smi_status_bank #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] stat_o
);
    logic [WIDTH-1:0] stat_d, stat_q;

    // Per-bit sticky cell: an event in the same cycle overrides a clear
    for (genvar b = 0; b < WIDTH; b++) begin : g_cell
        always_comb begin
            stat_d[b] = set_i[b] | (stat_q[b] & ~clr_i[b]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/smi_group_ctrl.sv
module smi_group_ctrl
    import smi_pkg::*;
#(
    parameter int unsigned       NUM_SRC   = 8,
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'hB4,
    parameter int unsigned       ROUTE_BIT = 0,
    parameter int unsigned       FRAME_BIT = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_evt_i,
    input  logic               kbc_pin_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               smi_n_o,
    output logic               smi_frame_o
);
    localparam logic [DATA_W-1:0] EN_B_MASK =
        (DATA_W'(1) << ROUTE_BIT) | (DATA_W'(1) << FRAME_BIT);

    typedef struct packed {
        logic [NUM_SRC-1:0] en_a;
        logic [DATA_W-1:0]  en_b;
        logic               smi_n;
        logic               frame;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic                 hit;
    smi_slot_e            slot;
    logic [NUM_SLOTS-1:0] wr_sel;
    logic [NUM_SRC-1:0]   stat_a, clr_a;
    logic [0:0]           stat_b, clr_b;
    logic                 group;

    smi_reg_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) i_decode (
        .addr_i  (reg_addr_i),
        .wr_i    (reg_wr_i),
        .hit_o   (hit),
        .slot_o  (slot),
        .wr_sel_o(wr_sel)
    );

    smi_status_bank #(.WIDTH(NUM_SRC)) i_bank_a (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (src_evt_i),
        .clr_i (clr_a),
        .stat_o(stat_a)
    );

    smi_status_bank #(.WIDTH(1)) i_bank_b (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (kbc_pin_i),
        .clr_i (clr_b),
        .stat_o(stat_b)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        clr_a  = wr_sel[SLOT_ST_A] ? reg_wdata_i[NUM_SRC-1:0] : '0;
        clr_b  = wr_sel[SLOT_ST_B] ? reg_wdata_i[ROUTE_BIT]   : 1'b0;

        if (wr_sel[SLOT_EN_A]) begin
            ctrl_d.en_a = reg_wdata_i[NUM_SRC-1:0];
        end
        if (wr_sel[SLOT_EN_B]) begin
            ctrl_d.en_b = reg_wdata_i & EN_B_MASK;
        end

        group = (|(stat_a & ctrl_q.en_a)) | (stat_b[0] & ctrl_q.en_b[ROUTE_BIT]);
        ctrl_d.smi_n = ~group;
        ctrl_d.frame = group & ctrl_q.en_b[FRAME_BIT];

        reg_rdata_o = '0;
        if (hit) begin
            unique case (slot)
                SLOT_EN_A: reg_rdata_o = DATA_W'(ctrl_q.en_a);
                SLOT_EN_B: reg_rdata_o = ctrl_q.en_b;
                SLOT_ST_A: reg_rdata_o = DATA_W'(stat_a);
                SLOT_ST_B: reg_rdata_o = DATA_W'(stat_b) << ROUTE_BIT;
                default:   reg_rdata_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q       <= '0;
            ctrl_q.smi_n <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign smi_n_o     = ctrl_q.smi_n;
    assign smi_frame_o = ctrl_q.frame;
endmodule

// File: rtl/smi_group_checker.sv
module smi_group_checker #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] src_evt_i,
    input logic               reg_wr_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic [DATA_W-1:0]  reg_wdata_i,
    input logic [NUM_SRC-1:0] stat_a,
    input logic [NUM_SRC-1:0] en_a,
    input logic               smi_n_o,
    input logic               smi_frame_o
);
    // While reset is held, the pin is released at the following edge
    assert_reset_idle_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (smi_n_o && !smi_frame_o));

    // An event always latches, independent of enables
    assert_evt_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|src_evt_i) |=> ((stat_a & $past(src_evt_i)) == $past(src_evt_i)));

    // No status bit rises without its event
    assert_no_spurious_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((stat_a & ~$past(stat_a) & ~$past(src_evt_i)) == '0));

    // A one written to status A clears bits whose event is quiet
    assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == ADDR_W'('hB6))
        |=> ((stat_a & $past(reg_wdata_i[NUM_SRC-1:0] & ~src_evt_i)) == '0));

    // An event wins over a simultaneous clear
    assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == ADDR_W'('hB6) && (|(src_evt_i & reg_wdata_i[NUM_SRC-1:0])))
        |=> ((stat_a & $past(src_evt_i)) == $past(src_evt_i)));

    // An enabled latched source drives the pin low on the next edge
    assert_group_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(stat_a & en_a)) |=> !smi_n_o);

    // The frame request never appears without the pin asserted
    assert_frame_implies_pin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smi_frame_o |-> !smi_n_o);
endmodule

bind smi_group_ctrl smi_group_checker #(
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_smi_group_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_evt_i  (src_evt_i),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .stat_a     (stat_a),
    .en_a       (ctrl_q.en_a),
    .smi_n_o    (smi_n_o),
    .smi_frame_o(smi_frame_o)
);

// File: tb/test_smi_group_ctrl.sv
module test_smi_group_ctrl;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [7:0] src_evt_i = '0;
    logic       kbc_pin_i = 1'b0;
    logic [7:0] reg_addr_i = '0;
    logic       reg_wr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       smi_n_o;
    logic       smi_frame_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk_i = ~clk_i;

    smi_group_ctrl i_smi_group_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_evt_i  (src_evt_i),
        .kbc_pin_i  (kbc_pin_i),
        .reg_addr_i (reg_addr_i),
        .reg_wr_i   (reg_wr_i),
        .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o),
        .smi_n_o    (smi_n_o),
        .smi_frame_o(smi_frame_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        tick();
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr_i = a;
        #0.1;
        d = reg_rdata_o;
    endtask

    task automatic pulse(input logic [7:0] m);
        src_evt_i = m;
        tick();
        src_evt_i = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 pin", {7'd0, smi_n_o}, 8'h01);
        chk("R1 frame", {7'd0, smi_frame_o}, 8'h00);
        for (int a = 'hB4; a <= 'hB7; a++) begin
            rd(8'(a), d);
            chk("R1 reg", d, 8'h00);
        end
    endtask

    task automatic t_enable_rw();
        logic [7:0] d;
        wr(8'hB4, 8'hA5); rd(8'hB4, d); chk("R2 en_a", d, 8'hA5);
        wr(8'hB5, 8'hFF); rd(8'hB5, d); chk("R2 en_b mask", d, 8'h41);
        wr(8'hB4, 8'h00); wr(8'hB5, 8'h00);
        rd(8'hB5, d); chk("R2 en_b clear", d, 8'h00);
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        pulse(8'h81);
        rd(8'hB6, d); chk("R3 latch disabled", d, 8'h81);
        tick();
        chk("R3 pin idle when disabled", {7'd0, smi_n_o}, 8'h01);
        rd(8'hB6, d); chk("R3 held", d, 8'h81);
    endtask

    task automatic t_w1c();
        logic [7:0] d;
        wr(8'hB6, 8'h00); rd(8'hB6, d); chk("R4 zero write", d, 8'h81);
        wr(8'hB6, 8'h80); rd(8'hB6, d); chk("R4 one clears", d, 8'h01);
        wr(8'hB6, 8'hFF); rd(8'hB6, d); chk("R4 all clear", d, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        pulse(8'h08);
        src_evt_i = 8'h04;
        wr(8'hB6, 8'h0C);
        src_evt_i = '0;
        rd(8'hB6, d); chk("R5 set wins", d, 8'h04);
        wr(8'hB6, 8'hFF);
    endtask

    task automatic t_group();
        logic [7:0] d;
        wr(8'hB4, 8'h10);
        pulse(8'h01);
        tick();
        chk("R6 other source", {7'd0, smi_n_o}, 8'h01);
        pulse(8'h10);
        chk("R6 not yet", {7'd0, smi_n_o}, 8'h01);
        tick();
        chk("R6 asserted", {7'd0, smi_n_o}, 8'h00);
        wr(8'hB6, 8'h10);
        tick();
        chk("R6 released", {7'd0, smi_n_o}, 8'h01);
        rd(8'hB6, d); chk("R6 other kept", d, 8'h01);
        wr(8'hB6, 8'hFF);
    endtask

    task automatic t_disable();
        logic [7:0] d;
        pulse(8'h10);
        tick();
        chk("R10 on", {7'd0, smi_n_o}, 8'h00);
        wr(8'hB4, 8'h00);
        chk("R10 one cycle", {7'd0, smi_n_o}, 8'h00);
        tick();
        chk("R10 off", {7'd0, smi_n_o}, 8'h01);
        rd(8'hB6, d); chk("R10 status kept", d, 8'h10);
        wr(8'hB6, 8'hFF);
    endtask

    task automatic t_kbc();
        logic [7:0] d;
        kbc_pin_i = 1'b1; tick(); kbc_pin_i = 1'b0;
        rd(8'hB7, d); chk("R7 latch", d, 8'h01);
        tick();
        chk("R7 unrouted", {7'd0, smi_n_o}, 8'h01);
        wr(8'hB5, 8'h01);
        tick();
        chk("R7 routed", {7'd0, smi_n_o}, 8'h00);
        chk("R8 no frame", {7'd0, smi_frame_o}, 8'h00);
        wr(8'hB7, 8'h01);
        tick();
        chk("R7 cleared", {7'd0, smi_n_o}, 8'h01);
        wr(8'hB5, 8'h00);
    endtask

    task automatic t_frame();
        wr(8'hB5, 8'h40);
        wr(8'hB4, 8'h02);
        pulse(8'h02);
        tick();
        chk("R8 frame on", {6'd0, smi_frame_o, smi_n_o}, 8'h02);
        wr(8'hB5, 8'h00);
        tick();
        chk("R8 frame off", {6'd0, smi_frame_o, smi_n_o}, 8'h00);
        wr(8'hB6, 8'hFF); wr(8'hB4, 8'h00);
    endtask

    task automatic t_decode();
        logic [7:0] d;
        wr(8'hB3, 8'hFF);
        wr(8'hB8, 8'hFF);
        rd(8'hB4, d); chk("R9 en_a untouched", d, 8'h00);
        rd(8'hB5, d); chk("R9 en_b untouched", d, 8'h00);
        rd(8'hB8, d); chk("R9 read outside", d, 8'h00);
        pulse(8'h20);
        wr(8'hBA, 8'hFF);
        rd(8'hB6, d); chk("R9 status untouched", d, 8'h20);
        wr(8'hB6, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        tick();
        t_enable_rw();
        t_sticky();
        t_w1c();
        t_collide();
        t_group();
        t_disable();
        t_kbc();
        t_frame();
        t_decode();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule